// File: doc/BRIEF.md
# Receive Byte Queue with Batched Interrupt

This block sits between a serial receiver and a processor bus. Every byte the receiver marks valid is stored in a small first-in first-out queue. The processor drains the queue through a pop strobe, with the oldest byte always shown on the read port. The fill level and the empty and full states are visible as outputs.

The interrupt request rises only when the queue holds a programmable number of bytes, so the processor takes one interrupt for several bytes rather than one per byte. A threshold of one gives the per-byte behaviour that simple polling drivers expect. A second cause covers the tail of a burst. If bytes are waiting and the line has been quiet for a programmable number of character times, the request rises as well. One character time is ten bit times, and the clocks per bit are a parameter. A byte that arrives while the queue is full is thrown away and sets a sticky overrun flag. Only a write-1-to-clear strobe clears that flag.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset the queue is empty (`empty`=1, `level`=0, `full`=0) and `irq`, `irq_thresh`, `irq_idle` and `overrun` are all 0.
- R2: Bytes leave in arrival order. While the queue is not empty, `rd_data` shows the oldest stored byte, and a pop moves on to the next one.
- R3: `level` counts accepted bytes minus effective pops and never exceeds DEPTH. `full` is 1 exactly when `level` equals DEPTH.
- R4: When `thresh` is non-zero, `irq_thresh` is 1 exactly when `level` >= `thresh`, in the same cycle the level changes. It falls as soon as the level drops below the threshold. A `thresh` of 0 holds `irq_thresh` at 0.
- R5: With `thresh`=1, `irq_thresh` rises after the first byte is stored and falls when the queue becomes empty.
- R6: A byte offered while the queue is full and no pop is present is discarded. The stored bytes and `level` are unchanged, and `overrun` reads 1 from the following cycle.
- R7: `overrun` stays 1 until a cycle with `ovr_clear`=1. If a discard and `ovr_clear` fall in the same cycle, the flag stays set.
- R8: A byte offered in the same cycle as a pop on a full queue is accepted. `level` stays at DEPTH and `overrun` does not set, and the new byte comes out after the older ones.
- R9: With `idle_chars` non-zero, `irq_idle` rises once the queue is non-empty and no push or pop has occurred for `idle_chars` x 10 x CLKS_PER_BIT cycles. It rises exactly that many cycles after the cycle of the last push or pop. An `idle_chars` of 0 holds `irq_idle` at 0.
- R10: An effective pop clears `irq_idle` in the next cycle. Any push or pop restarts the idle count.
- R11: A pop on an empty queue has no effect. The queue stays empty, and the next byte stored is the one read out.
- R12: `irq` is 1 whenever any of `irq_thresh`, `irq_idle` or `overrun` is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receiver offers a byte this cycle |
| rx_data | input | 8 | Byte offered by the receiver |
| pop | input | 1 | Processor removes the oldest byte |
| thresh | input | $clog2(DEPTH+1) | Fill level that raises the interrupt (0 disables) |
| idle_chars | input | IDLE_W | Quiet character times before the timeout interrupt (0 disables) |
| ovr_clear | input | 1 | Write-1-to-clear strobe for the overrun flag |
| rd_data | output | 8 | Oldest stored byte |
| level | output | $clog2(DEPTH+1) | Number of stored bytes |
| empty | output | 1 | Queue holds no byte |
| full | output | 1 | Queue holds DEPTH bytes |
| irq_thresh | output | 1 | Fill-level cause |
| irq_idle | output | 1 | Idle-timeout cause |
| overrun | output | 1 | Sticky discard flag |
| irq | output | 1 | Combined interrupt request |

## Verification
Two collisions matter most. The first is a receiver byte landing in the same cycle as a processor pop while the queue is full, which must count as a swap and not as a discard. The bench fills the queue, drives both strobes on one edge, and then expects `overrun` low, `level` at DEPTH and the new byte last in the drained order. The second is a discard coinciding with the overrun clear strobe. The bench drives both together and expects the flag to remain set, then to fall on a clear alone.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Events decoded from the strobes in one cycle.
  typedef struct packed {
    logic push_ok;
    logic pop_ok;
    logic drop;
  } rxq_evt_t;

  // Clock cycles in one character: start, data and stop bits.
  function automatic int unsigned char_clocks(input int unsigned clks_per_bit,
                                              input int unsigned bits_per_char);
    return clks_per_bit * bits_per_char;
  endfunction

  // Decode the strobes. A pop frees a slot in the same cycle, so a push
  // on a full queue is accepted when it comes together with a pop.
  function automatic rxq_evt_t decode_evt(input logic rx_valid, input logic pop,
                                          input logic empty, input logic full);
    rxq_evt_t e;
    e.pop_ok  = pop & ~empty;
    e.push_ok = rx_valid & (~full | pop);
    e.drop    = rx_valid & full & ~pop;
    return e;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_ok,
  input  logic              pop_ok,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level,
  output logic              empty,
  output logic              full
);

  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [DATA_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  // New level from the old level and the accepted events.
  function automatic logic [LVL_W-1:0] next_level(input logic [LVL_W-1:0] lv,
                                                  input logic up, input logic dn);
    case ({up, dn})
      2'b10:   return lv + LVL_W'(1);
      2'b01:   return lv - LVL_W'(1);
      default: return lv;
    endcase
  endfunction

  // Pointer wrap: free for a power-of-two depth, explicit compare otherwise.
  generate
    if (POW2) begin : g_wrap_free
      assign wr_nxt = wr_ptr + PTR_W'(1);
      assign rd_nxt = rd_ptr + PTR_W'(1);
    end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else begin
      if (push_ok) begin
        slot[wr_ptr] <= wr_data;
        wr_ptr       <= wr_nxt;
      end
      if (pop_ok) rd_ptr <= rd_nxt;
      level <= next_level(level, push_ok, pop_ok);
    end
  end

  assign rd_data = slot[rd_ptr];
  assign empty   = (level == '0);
  assign full    = (level == LVL_W'(DEPTH));

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int CLKS_PER_BIT  = 16,
  parameter int BITS_PER_CHAR = 10,
  parameter int IDLE_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              activity,
  input  logic              empty,
  input  logic [IDLE_W-1:0] idle_chars,
  output logic              timeout
);

  localparam int unsigned CHAR_CLKS = rxq_pkg::char_clocks(CLKS_PER_BIT, BITS_PER_CHAR);
  localparam int CYC_W = (CHAR_CLKS > 1) ? $clog2(CHAR_CLKS) : 1;

  logic [CYC_W-1:0]  cyc;
  logic [IDLE_W-1:0] chars;
  logic              char_done;

  function automatic logic [IDLE_W-1:0] sat_inc(input logic [IDLE_W-1:0] v);
    return (v == '1) ? v : v + IDLE_W'(1);
  endfunction

  function automatic logic expired(input logic [IDLE_W-1:0] seen,
                                   input logic [IDLE_W-1:0] limit,
                                   input logic              none_waiting);
    return (limit != '0) && !none_waiting && (seen >= limit);
  endfunction

  assign char_done = (cyc == CYC_W'(CHAR_CLKS - 1));

  // Character times since the last push or pop. Held at zero while empty.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc   <= '0;
      chars <= '0;
    end else if (activity || empty) begin
      cyc   <= '0;
      chars <= '0;
    end else if (char_done) begin
      cyc   <= '0;
      chars <= sat_inc(chars);
    end else begin
      cyc <= cyc + CYC_W'(1);
    end
  end

  assign timeout = expired(chars, idle_chars, empty);

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] thresh,
  input  logic             drop,
  input  logic             ovr_clear,
  output logic             irq_thresh,
  output logic             overrun
);

  function automatic logic reached(input logic [LVL_W-1:0] lv,
                                   input logic [LVL_W-1:0] th);
    return (th != '0) && (lv >= th);
  endfunction

  assign irq_thresh = reached(level, thresh);

  // A discard wins over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)         overrun <= 1'b0;
    else if (drop)      overrun <= 1'b1;
    else if (ovr_clear) overrun <= 1'b0;
  end

endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
  parameter int DEPTH         = 8,
  parameter int CLKS_PER_BIT  = 16,
  parameter int BITS_PER_CHAR = 10,
  parameter int IDLE_W        = 4,
  localparam int DATA_W       = 8,
  localparam int LVL_W        = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              pop,
  input  logic [LVL_W-1:0]  thresh,
  input  logic [IDLE_W-1:0] idle_chars,
  input  logic              ovr_clear,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level,
  output logic              empty,
  output logic              full,
  output logic              irq_thresh,
  output logic              irq_idle,
  output logic              overrun,
  output logic              irq
);

  rxq_pkg::rxq_evt_t evt;
  logic push_ok, pop_ok, drop;

  assign evt     = rxq_pkg::decode_evt(rx_valid, pop, empty, full);
  assign push_ok = evt.push_ok;
  assign pop_ok  = evt.pop_ok;
  assign drop    = evt.drop;

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_ok (push_ok),
    .pop_ok  (pop_ok),
    .wr_data (rx_data),
    .rd_data (rd_data),
    .level   (level),
    .empty   (empty),
    .full    (full)
  );

  rxq_idle_timer #(
    .CLKS_PER_BIT  (CLKS_PER_BIT),
    .BITS_PER_CHAR (BITS_PER_CHAR),
    .IDLE_W        (IDLE_W)
  ) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .activity   (push_ok | pop_ok),
    .empty      (empty),
    .idle_chars (idle_chars),
    .timeout    (irq_idle)
  );

  rxq_flags #(.LVL_W(LVL_W)) flags_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .level      (level),
    .thresh     (thresh),
    .drop       (drop),
    .ovr_clear  (ovr_clear),
    .irq_thresh (irq_thresh),
    .overrun    (overrun)
  );

  assign irq = irq_thresh | irq_idle | overrun;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             pop,
  input logic             ovr_clear,
  input logic             full,
  input logic             empty,
  input logic [LVL_W-1:0] level,
  input logic             overrun,
  input logic             irq_thresh,
  input logic             irq_idle,
  input logic             push_ok,
  input logic             pop_ok,
  input logic             drop
);

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  assert_drop_sets_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overrun);

  assert_drop_keeps_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> full);

  assert_drop_not_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(drop && push_ok));

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clear) |=> overrun);

  assert_full_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && rx_valid && pop && !overrun && !ovr_clear) |=> (full && !overrun));

  assert_thresh_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_thresh |-> !empty);

  assert_idle_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_idle |-> !empty);

  assert_pop_clears_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |=> !irq_idle);

  assert_empty_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !rx_valid) |=> empty);

endmodule

bind rx_byte_queue rxq_checker #(.DEPTH(DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_valid   (rx_valid),
  .pop        (pop),
  .ovr_clear  (ovr_clear),
  .full       (full),
  .empty      (empty),
  .level      (level),
  .overrun    (overrun),
  .irq_thresh (irq_thresh),
  .irq_idle   (irq_idle),
  .push_ok    (push_ok),
  .pop_ok     (pop_ok),
  .drop       (drop)
);

// File: tb/rx_byte_queue_tb_top.sv
module rx_byte_queue_tb_top;

  localparam int DEPTH = 8;
  localparam int CPB   = 4;
  localparam int CHARC = CPB * 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       pop = 1'b0;
  logic [3:0] thresh = '0;
  logic [3:0] idle_chars = '0;
  logic       ovr_clear = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] level;
  logic       empty, full, irq_thresh, irq_idle, overrun, irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  rx_byte_queue #(.DEPTH(DEPTH), .CLKS_PER_BIT(CPB)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .pop(pop),
    .thresh(thresh), .idle_chars(idle_chars), .ovr_clear(ovr_clear),
    .rd_data(rd_data), .level(level), .empty(empty), .full(full),
    .irq_thresh(irq_thresh), .irq_idle(irq_idle), .overrun(overrun), .irq(irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [7:0] b);
    chk(req, rd_data, b);
    pop = 1'b1;
    tick();
    pop = 1'b0;
  endtask

  task automatic drain();
    while (!empty) begin
      pop = 1'b1; tick(); pop = 1'b0;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
    chk("R1 empty", empty, 1); chk("R1 level", level, 0); chk("R1 full", full, 0);
    chk("R1 irq", irq, 0); chk("R1 irq_thresh", irq_thresh, 0);
    chk("R1 irq_idle", irq_idle, 0); chk("R1 overrun", overrun, 0);
  endtask

  task automatic t_order();
    thresh = 0;
    for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i));
    chk("R3 level after 5", level, 5);
    chk("R3 full low", full, 0);
    for (int i = 0; i < 5; i++) pop_expect("R2 order", 8'hA0 + 8'(i));
    chk("R3 level after drain", level, 0);
  endtask

  task automatic t_threshold();
    thresh = 6;
    for (int i = 0; i < 5; i++) push(8'(i));
    chk("R4 below threshold", irq_thresh, 0);
    chk("R12 irq low", irq, 0);
    push(8'h05);
    chk("R4 at threshold", irq_thresh, 1);
    chk("R12 irq high", irq, 1);
    pop_expect("R2 order", 8'h00);
    chk("R4 falls below threshold", irq_thresh, 0);
    thresh = 0; #1;
    chk("R4 zero disables", irq_thresh, 0);
    drain();
  endtask

  task automatic t_per_byte();
    thresh = 1; #1;
    chk("R5 empty no irq", irq_thresh, 0);
    push(8'h42);
    chk("R5 first byte irq", irq_thresh, 1);
    pop_expect("R5 data", 8'h42);
    chk("R5 empty clears", irq_thresh, 0);
    thresh = 0;
  endtask

  task automatic t_overrun();
    for (int i = 0; i < DEPTH; i++) push(8'h10 + 8'(i));
    chk("R3 full", full, 1);
    chk("R6 no overrun yet", overrun, 0);
    push(8'hEE);
    chk("R6 overrun set", overrun, 1);
    chk("R6 level kept", level, DEPTH);
    chk("R12 irq by overrun", irq, 1);
    tick(); tick(); tick();
    chk("R7 sticky", overrun, 1);
    for (int i = 0; i < DEPTH; i++) pop_expect("R6 content kept", 8'h10 + 8'(i));
    chk("R7 sticky after drain", overrun, 1);
    ovr_clear = 1'b1; tick(); ovr_clear = 1'b0;
    chk("R7 cleared", overrun, 0);
    chk("R12 irq low", irq, 0);
    // discard and clear in the same cycle: flag stays set
    for (int i = 0; i < DEPTH; i++) push(8'h30 + 8'(i));
    rx_valid = 1'b1; rx_data = 8'hDD; ovr_clear = 1'b1;
    tick();
    rx_valid = 1'b0; ovr_clear = 1'b0;
    chk("R7 set wins over clear", overrun, 1);
    ovr_clear = 1'b1; tick(); ovr_clear = 1'b0;
    chk("R7 clear alone", overrun, 0);
    drain();
  endtask

  task automatic t_full_swap();
    for (int i = 0; i < DEPTH; i++) push(8'h20 + 8'(i));
    rx_valid = 1'b1; rx_data = 8'h99; pop = 1'b1;
    tick();
    rx_valid = 1'b0; pop = 1'b0;
    chk("R8 no overrun", overrun, 0);
    chk("R8 level stays full", level, DEPTH);
    for (int i = 1; i < DEPTH; i++) pop_expect("R8 order", 8'h20 + 8'(i));
    pop_expect("R8 new byte last", 8'h99);
    chk("R8 empty after", empty, 1);
  endtask

  task automatic t_idle();
    idle_chars = 2;
    push(8'h61);
    repeat (2 * CHARC - 1) tick();
    chk("R9 not yet", irq_idle, 0);
    tick();
    chk("R9 timeout", irq_idle, 1);
    chk("R12 irq by idle", irq, 1);
    push(8'h62);
    chk("R10 push restarts", irq_idle, 0);
    repeat (CHARC + 20) tick();
    push(8'h63);
    repeat (2 * CHARC - 1) tick();
    chk("R10 restart not yet", irq_idle, 0);
    tick();
    chk("R10 restart fires", irq_idle, 1);
    pop_expect("R2 order", 8'h61);
    chk("R10 pop clears", irq_idle, 0);
    repeat (2 * CHARC) tick();
    chk("R10 fires again", irq_idle, 1);
    drain();
    chk("R9 empty no idle", irq_idle, 0);
    idle_chars = 0;
    push(8'h64);
    repeat (4 * CHARC) tick();
    chk("R9 zero disables", irq_idle, 0);
    drain();
  endtask

  task automatic t_empty_pop();
    pop = 1'b1; tick(); pop = 1'b0;
    chk("R11 level", level, 0);
    chk("R11 empty", empty, 1);
    push(8'h55);
    chk("R11 level one", level, 1);
    pop_expect("R11 data", 8'h55);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_order();
    t_threshold();
    t_per_byte();
    t_overrun();
    t_full_swap();
    t_idle();
    t_empty_pop();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule